// File: doc/BRIEF.md
# External Write Queue with Block Drain

This block sits between a processor's data cache and a 32-bit multiplexed address/data bus. It queues every write bound for external memory: stores to uncached space, write-through stores and dirty-line evictions. The core hands a write over in a single cycle and keeps running while the queue empties onto the bus in the background. Two flags, full and empty, tell the core whether another write can be accepted.

The queue has four slots, and each slot holds an address with a 64-bit data field. A single write fills one slot and leaves as one address cycle followed by one data cycle. A dirty-line eviction is eight 32-bit words. It is loaded in one cycle into all four slots, and only when the queue is empty. It leaves as one block address cycle followed by eight data cycles. Before it removes an address from the bus, the block samples a ready input from the memory side. If that input is low, the same address cycle is issued again.

Requests that cannot be accepted are dropped, and a one-cycle error pulse reports them.

Top module: `ext_wrbuf`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `empty` is 1, `full` is 0, `ovf_err` is 0, and `bus_cmd`, `bus_ad` and `bus_size` are all 0.
- R2: A `st_req` is accepted when `full` is 0 and `ln_req` is low. It produces an address cycle with `bus_cmd`=1, `bus_ad` equal to the full `st_addr` (the low three bits keep the byte offset) and `bus_size` equal to `st_size`, the byte count 1 to 4. This is followed by exactly one data cycle with `bus_cmd`=4 and `bus_ad`=`st_data`.
- R3: Queued writes reach the bus strictly in the order they were accepted. No data cycle appears unless it follows its own address cycle or another data cycle of the same block.
- R4: During an address cycle, `bus_wr_rdy` is sampled at the closing clock edge. If it is low, the next cycle repeats the same `bus_cmd` and `bus_ad`. If it is high, the next cycle is the first data cycle.
- R5: An `ln_req` is accepted only when `empty` is 1, and `full` is 1 on the next cycle. The line leaves as a block address cycle with `bus_cmd`=2, `bus_ad`=`ln_addr` and `bus_size`=0. Then come eight data cycles carrying word w = `ln_data[32w+31:32w]` for w = 0 to 7. The first seven have `bus_cmd`=3 and the last has `bus_cmd`=4.
- R6: `full` is 1 exactly when four slots are occupied, and `empty` is 1 exactly when none is occupied. Both flags follow the occupancy that the previous clock edge produced. A single write frees its slot with its data cycle. A block frees one slot with every second data word.
- R7: A request is ignored, and `ovf_err` is 1 on the following cycle only, in each of these cases: `st_req` while `full` is 1, `ln_req` while `empty` is 0, or `st_req` together with `ln_req`. In the last case the line is still accepted if `empty` is 1.
- R8: When no transfer is driven, `bus_cmd`, `bus_ad` and `bus_size` are 0. After each `bus_cmd`=4 cycle there is exactly one such idle cycle. A write accepted into an empty queue reaches the bus two cycles after it is accepted.
- R9: Data cycles advance one word per clock whatever the level of `bus_wr_rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_req | input | 1 | Single write request |
| st_addr | input | 32 | Byte address of the single write |
| st_data | input | 32 | Data of the single write |
| st_size | input | 3 | Byte count of the single write, 1 to 4 |
| ln_req | input | 1 | Line writeback request |
| ln_addr | input | 32 | Line base address, 32-byte aligned |
| ln_data | input | 256 | Eight line words, word 0 in the low bits |
| full | output | 1 | All four slots occupied |
| empty | output | 1 | No slot occupied |
| ovf_err | output | 1 | Pulse: the previous cycle's request was dropped |
| bus_ad | output | 32 | Multiplexed address/data |
| bus_cmd | output | 3 | 0 idle, 1 single address, 2 block address, 3 data, 4 last data |
| bus_size | output | 3 | Byte count during a single address cycle, else 0 |
| bus_wr_rdy | input | 1 | Memory side ready to take the write |

## Verification
The hardest situation to reach from the ports is a block drain with single writes slipping into the slots as they free up. Those single writes must then go out after the eighth word and in arrival order, while the memory side stalls some address cycles. The directed part of the bench loads a line and then offers a single store on every cycle of its drain, with the ready input toggling. The random part mixes stores, rare line requests and a ready input that is low about a third of the time. A cycle-level model predicts every bus cycle, the flags and the error pulse.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;

    localparam int WB_DEPTH  = 4;
    localparam int BUS_W     = 32;
    localparam int ENT_WORDS = 2;
    localparam int SIZE_W    = 3;
    localparam int ENT_W     = BUS_W * ENT_WORDS;
    localparam int ENT_BYTES = ENT_W / 8;

    typedef logic [BUS_W-1:0] word_t;

    typedef struct packed {
        logic              blk;
        logic [SIZE_W-1:0] size;
        word_t             addr;
        logic [ENT_W-1:0]  data;
    } wb_entry_t;

    typedef enum logic [2:0] {
        CMD_IDLE     = 3'd0,
        CMD_ADDR_ONE = 3'd1,
        CMD_ADDR_BLK = 3'd2,
        CMD_DATA     = 3'd3,
        CMD_DATA_END = 3'd4
    } bus_cmd_e;

    typedef enum logic [1:0] {
        DR_IDLE,
        DR_ADDR,
        DR_DATA
    } drain_st_e;

    function automatic word_t entry_word(wb_entry_t e, int unsigned idx);
        return e.data[idx*BUS_W +: BUS_W];
    endfunction

endpackage

// File: rtl/wrbuf_admit.sv
module wrbuf_admit
    import wrbuf_pkg::*;
#(
    parameter int DEPTH = WB_DEPTH,
    localparam int LINE_W = DEPTH * ENT_W
) (
    input  logic              st_req,
    input  word_t             st_addr,
    input  word_t             st_data,
    input  logic [SIZE_W-1:0] st_size,
    input  logic              ln_req,
    input  word_t             ln_addr,
    input  logic [LINE_W-1:0] ln_data,
    input  logic              full,
    input  logic              empty,
    output logic              push_one,
    output logic              push_line,
    output logic              reject,
    output wb_entry_t         one_ent,
    output wb_entry_t         line_ent [DEPTH]
);

    // a line request always wins the cycle; a store beside it is dropped
    always_comb begin
        push_line = ln_req && empty;
        push_one  = st_req && !ln_req && !full;
        reject    = (ln_req && !empty) || (st_req && (ln_req || full));
    end

    always_comb begin
        one_ent      = '0;
        one_ent.blk  = 1'b0;
        one_ent.size = st_size;
        one_ent.addr = st_addr;
        one_ent.data[BUS_W-1:0] = st_data;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_line
        always_comb begin
            line_ent[i].blk  = 1'b1;
            line_ent[i].size = '0;
            line_ent[i].addr = ln_addr + word_t'(i * ENT_BYTES);
            line_ent[i].data = ln_data[i*ENT_W +: ENT_W];
        end
    end

endmodule

// File: rtl/wrbuf_store.sv
module wrbuf_store
    import wrbuf_pkg::*;
#(
    parameter int DEPTH = WB_DEPTH,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push_one,
    input  logic      push_line,
    input  logic      reject,
    input  logic      pop,
    input  wb_entry_t one_ent,
    input  wb_entry_t line_ent [DEPTH],
    output wb_entry_t head_ent,
    output logic      full,
    output logic      empty,
    output logic      err
);

    wb_entry_t        slot [DEPTH];
    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    function automatic logic [PTR_W-1:0] ring_inc(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        cnt_n = cnt_q;
        if (push_line)     cnt_n = CNT_W'(DEPTH);
        else if (push_one) cnt_n = cnt_n + CNT_W'(1);
        if (pop)           cnt_n = cnt_n - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            full   <= 1'b0;
            empty  <= 1'b1;
            err    <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            full  <= (cnt_n == CNT_W'(DEPTH));
            empty <= (cnt_n == '0);
            err   <= reject;
            if (push_line) begin
                head_q <= '0;
                tail_q <= '0;
            end else begin
                if (push_one) tail_q <= ring_inc(tail_q);
                if (pop)      head_q <= ring_inc(head_q);
            end
        end
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_line)
                slot[s] <= line_ent[s];
            else if (push_one && tail_q == PTR_W'(s))
                slot[s] <= one_ent;
        end
    end

    assign head_ent = slot[head_q];

endmodule

// File: rtl/wrbuf_drain.sv
module wrbuf_drain
    import wrbuf_pkg::*;
#(
    parameter int DEPTH = WB_DEPTH,
    localparam int LINE_WORDS = DEPTH * ENT_WORDS,
    localparam int WIDX_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              empty,
    input  wb_entry_t         head_ent,
    input  logic              bus_wr_rdy,
    output logic              pop,
    output bus_cmd_e          cmd,
    output word_t             ad,
    output logic [SIZE_W-1:0] size
);

    drain_st_e         st_q;
    logic [WIDX_W-1:0] widx_q;
    int unsigned       half;
    logic              last_word;
    logic              xfer_end;

    always_comb begin
        half      = int'(widx_q) % ENT_WORDS;
        last_word = (widx_q == WIDX_W'(LINE_WORDS - 1));
        xfer_end  = (st_q == DR_DATA) && (!head_ent.blk || last_word);
        pop       = (st_q == DR_DATA) &&
                    (!head_ent.blk || half == ENT_WORDS - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= DR_IDLE;
            widx_q <= '0;
        end else begin
            unique case (st_q)
                DR_IDLE: begin
                    widx_q <= '0;
                    if (!empty) st_q <= DR_ADDR;
                end
                DR_ADDR: begin
                    if (bus_wr_rdy) st_q <= DR_DATA;
                end
                DR_DATA: begin
                    widx_q <= widx_q + WIDX_W'(1);
                    if (xfer_end) st_q <= DR_IDLE;
                end
                default: st_q <= DR_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd  = CMD_IDLE;
        ad   = '0;
        size = '0;
        unique case (st_q)
            DR_ADDR: begin
                cmd  = head_ent.blk ? CMD_ADDR_BLK : CMD_ADDR_ONE;
                ad   = head_ent.addr;
                size = head_ent.blk ? '0 : head_ent.size;
            end
            DR_DATA: begin
                cmd = xfer_end ? CMD_DATA_END : CMD_DATA;
                ad  = entry_word(head_ent, head_ent.blk ? half : 0);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ext_wrbuf.sv
module ext_wrbuf
    import wrbuf_pkg::*;
#(
    parameter int DEPTH = WB_DEPTH,
    localparam int LINE_W = DEPTH * ENT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_req,
    input  logic [BUS_W-1:0]  st_addr,
    input  logic [BUS_W-1:0]  st_data,
    input  logic [SIZE_W-1:0] st_size,
    input  logic              ln_req,
    input  logic [BUS_W-1:0]  ln_addr,
    input  logic [LINE_W-1:0] ln_data,
    output logic              full,
    output logic              empty,
    output logic              ovf_err,
    output logic [BUS_W-1:0]  bus_ad,
    output logic [2:0]        bus_cmd,
    output logic [SIZE_W-1:0] bus_size,
    input  logic              bus_wr_rdy
);

    logic      push_one, push_line, reject, pop;
    wb_entry_t one_ent;
    wb_entry_t line_ent [DEPTH];
    wb_entry_t head_ent;
    bus_cmd_e  cmd;

    wrbuf_admit #(.DEPTH(DEPTH)) u_admit (
        .st_req    (st_req),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .st_size   (st_size),
        .ln_req    (ln_req),
        .ln_addr   (ln_addr),
        .ln_data   (ln_data),
        .full      (full),
        .empty     (empty),
        .push_one  (push_one),
        .push_line (push_line),
        .reject    (reject),
        .one_ent   (one_ent),
        .line_ent  (line_ent)
    );

    wrbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push_one  (push_one),
        .push_line (push_line),
        .reject    (reject),
        .pop       (pop),
        .one_ent   (one_ent),
        .line_ent  (line_ent),
        .head_ent  (head_ent),
        .full      (full),
        .empty     (empty),
        .err       (ovf_err)
    );

    wrbuf_drain #(.DEPTH(DEPTH)) u_drain (
        .clk        (clk),
        .rst        (rst),
        .empty      (empty),
        .head_ent   (head_ent),
        .bus_wr_rdy (bus_wr_rdy),
        .pop        (pop),
        .cmd        (cmd),
        .ad         (bus_ad),
        .size       (bus_size)
    );

    assign bus_cmd = cmd;

endmodule

// File: rtl/ext_wrbuf_chk.sv
module ext_wrbuf_chk (
    input logic        clk,
    input logic        rst,
    input logic        st_req,
    input logic        ln_req,
    input logic        full,
    input logic        empty,
    input logic        ovf_err,
    input logic [31:0] bus_ad,
    input logic [2:0]  bus_cmd,
    input logic [2:0]  bus_size,
    input logic        bus_wr_rdy
);

    logic is_addr, is_data;
    assign is_addr = (bus_cmd == 3'd1) || (bus_cmd == 3'd2);
    assign is_data = (bus_cmd == 3'd3) || (bus_cmd == 3'd4);

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(full && empty)); // R6

    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
        empty |-> (bus_cmd == 3'd0 && bus_ad == '0 && bus_size == '0)); // R8

    AST_ADDR_RETRY: assert property (@(posedge clk) disable iff (rst)
        (is_addr && !bus_wr_rdy) |=> (bus_cmd == $past(bus_cmd) && bus_ad == $past(bus_ad))); // R4

    AST_ADDR_TO_DATA: assert property (@(posedge clk) disable iff (rst)
        (is_addr && bus_wr_rdy) |=> is_data); // R4

    AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        is_data |-> ($past(bus_cmd) inside {3'd1, 3'd2, 3'd3})); // R3

    AST_SINGLE_ONE_DATA: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 3'd1 && bus_wr_rdy) |=> (bus_cmd == 3'd4)); // R2

    AST_BLOCK_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 3'd3) |=> is_data); // R9

    AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == 3'd4) |=> (bus_cmd == 3'd0)); // R8

    AST_REJECT_FULL: assert property (@(posedge clk) disable iff (rst)
        (st_req && full) |=> ovf_err); // R7

    AST_REJECT_LINE: assert property (@(posedge clk) disable iff (rst)
        (ln_req && !empty) |=> ovf_err); // R7

    AST_LINE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (ln_req && empty) |=> full); // R5

endmodule

bind ext_wrbuf ext_wrbuf_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .st_req     (st_req),
    .ln_req     (ln_req),
    .full       (full),
    .empty      (empty),
    .ovf_err    (ovf_err),
    .bus_ad     (bus_ad),
    .bus_cmd    (bus_cmd),
    .bus_size   (bus_size),
    .bus_wr_rdy (bus_wr_rdy)
);

// File: tb/ext_wrbuf_tb.sv
module ext_wrbuf_tb;

    localparam int DEPTH  = 4;
    localparam int LWORDS = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         st_req, ln_req, bus_wr_rdy;
    logic [31:0]  st_addr, st_data, ln_addr;
    logic [2:0]   st_size;
    logic [255:0] ln_data;
    logic         full, empty, ovf_err;
    logic [31:0]  bus_ad;
    logic [2:0]   bus_cmd, bus_size;

    always #10 clk = ~clk;

    ext_wrbuf u_dut (
        .clk(clk), .rst(rst),
        .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .st_size(st_size),
        .ln_req(ln_req), .ln_addr(ln_addr), .ln_data(ln_data),
        .full(full), .empty(empty), .ovf_err(ovf_err),
        .bus_ad(bus_ad), .bus_cmd(bus_cmd), .bus_size(bus_size),
        .bus_wr_rdy(bus_wr_rdy)
    );

    typedef struct {
        logic [2:0]  cmd;
        logic [31:0] ad;
        logic [2:0]  sz;
        bit          frees;
        string       tag;
    } beat_t;

    beat_t q[$];
    int    checks = 0;
    int    errors = 0;
    int    mcount = 0;
    bit    exp_err = 0;
    bit    idle_ok = 1;
    bit    done = 0;

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [255:0] rand_line();
        logic [255:0] v;
        for (int w = 0; w < LWORDS; w++) v[32*w +: 32] = $urandom;
        return v;
    endfunction

    task automatic check_outputs();
        chk(empty == (mcount == 0), "R6", "empty flag", {31'd0, empty}, {31'd0, mcount == 0});
        chk(full == (mcount == DEPTH), "R6", "full flag", {31'd0, full}, {31'd0, mcount == DEPTH});
        chk(ovf_err == exp_err, "R7", "error pulse", {31'd0, ovf_err}, {31'd0, exp_err});
        if (bus_cmd == 3'd0) begin
            chk(bus_ad == 0 && bus_size == 0, "R8", "idle bus ad", bus_ad, 0);
            if (q.size() != 0)
                chk(idle_ok, "R8", "idle while work pending", {29'd0, bus_cmd}, {29'd0, q[0].cmd});
        end else if (q.size() == 0) begin
            chk(0, "R3", "unexpected bus cycle cmd", {29'd0, bus_cmd}, 0);
        end else begin
            chk(bus_cmd == q[0].cmd, {"R3/", q[0].tag}, "bus_cmd", {29'd0, bus_cmd}, {29'd0, q[0].cmd});
            chk(bus_ad == q[0].ad, {"R3/", q[0].tag}, "bus_ad", bus_ad, q[0].ad);
            chk(bus_size == q[0].sz, {"R2/", q[0].tag}, "bus_size", {29'd0, bus_size}, {29'd0, q[0].sz});
        end
    endtask

    // called at a falling edge: check, drive, advance the model, wait one clock
    task automatic step(bit st, logic [31:0] sa, logic [31:0] sd, logic [2:0] ssz,
                        bit ln, logic [31:0] la, logic [255:0] ld, bit rdy);
        bit deq, popped_last, q_was_empty, acc_one, acc_line, rej;
        check_outputs();
        st_req = st; st_addr = sa; st_data = sd; st_size = ssz;
        ln_req = ln; ln_addr = la; ln_data = ld; bus_wr_rdy = rdy;
        deq = 0; popped_last = 0;
        if (bus_cmd != 3'd0 && q.size() != 0) begin
            if (bus_cmd == 3'd1 || bus_cmd == 3'd2) begin
                if (rdy) void'(q.pop_front());   // R4: retried when not ready
            end else begin
                deq = q[0].frees;
                popped_last = (bus_cmd == 3'd4);
                void'(q.pop_front());
            end
        end
        q_was_empty = (q.size() == 0);
        acc_line = ln && (mcount == 0);
        acc_one  = st && !ln && (mcount < DEPTH);
        rej      = (ln && mcount != 0) || (st && (ln || mcount == DEPTH));
        mcount   = mcount + (acc_line ? DEPTH : (acc_one ? 1 : 0)) - (deq ? 1 : 0);
        exp_err  = rej;
        if (acc_one) begin
            q.push_back('{3'd1, sa, ssz, 1'b0, "R2"});
            q.push_back('{3'd4, sd, 3'd0, 1'b1, "R2"});
        end
        if (acc_line) begin
            q.push_back('{3'd2, la, 3'd0, 1'b0, "R5"});
            for (int w = 0; w < LWORDS; w++)
                q.push_back('{(w == LWORDS-1) ? 3'd4 : 3'd3, ld[32*w +: 32], 3'd0,
                              (w % 2) == 1, "R9"});
        end
        idle_ok = popped_last || q_was_empty;
        @(negedge clk);
    endtask

    task automatic idle(int n, bit rdy);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, rdy);
    endtask

    task automatic store(logic [31:0] a, logic [31:0] d, logic [2:0] s, bit rdy);
        step(1, a, d, s, 0, 0, 0, rdy);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [255:0] ld;
        void'($urandom(32'd7341));
        rst = 1; st_req = 0; ln_req = 0; bus_wr_rdy = 0;
        st_addr = 0; st_data = 0; st_size = 0; ln_addr = 0; ln_data = 0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(empty == 1 && full == 0 && ovf_err == 0, "R1", "flags in reset",
            {29'd0, empty, full, ovf_err}, 32'h4);
        chk(bus_cmd == 0 && bus_ad == 0 && bus_size == 0, "R1", "bus in reset", bus_ad, 0);
        rst = 0;

        // R2, R4: single write with offset, memory side stalls the address cycle
        store(32'h1000_0003, 32'hCAFE_0001, 3'd1, 0);
        idle(4, 0);
        idle(6, 1);

        // R6, R7: fill four slots while stalled, then a fifth store is dropped
        for (int i = 0; i < DEPTH; i++) store(32'h2000_0000 + 4*i, 32'hA000_0000 + i, 3'd4, 0);
        chk(full == 1, "R6", "full after four stores", {31'd0, full}, 1);
        store(32'h2FFF_FFF0, 32'hDEAD_BEEF, 3'd2, 0);
        // R7: a line request while slots are held is dropped
        step(0, 0, 0, 0, 1, 32'h3000_0000, rand_line(), 0);
        idle(30, 1);
        chk(empty == 1, "R6", "empty after drain", {31'd0, empty}, 1);

        // R5, R9: line writeback with stores offered throughout its drain
        ld = rand_line();
        step(0, 0, 0, 0, 1, 32'h4000_0020, ld, 1);
        chk(full == 1, "R5", "full after line load", {31'd0, full}, 1);
        for (int i = 0; i < 14; i++) store(32'h5000_0000 + i, 32'hB000_0000 + i, 3'd3, i % 2);
        idle(40, 1);

        // R7: store and line together on an empty queue, line still taken
        step(1, 32'h6000_0001, 32'h1111_2222, 3'd1, 1, 32'h7000_0040, rand_line(), 1);
        idle(20, 1);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            bit st, ln, rdy;
            st  = ($urandom % 100) < 40;
            ln  = ($urandom % 100) < 6;
            rdy = ($urandom % 100) < 68;
            step(st, $urandom, $urandom, 3'(1 + $urandom % 4), ln,
                 {$urandom, 5'd0} & 32'hFFFF_FFE0, rand_line(), rdy);
        end
        idle(80, 1);
        chk(q.size() == 0, "R3", "all queued cycles seen", q.size(), 0);
        check_outputs();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule